// File: doc/BRIEF.md
# Working Register File with Self-Pointer

This block is the 32-entry, 8-bit general register file of a small 8-bit processor core. It has two read ports and one write port. Each port resolves its own register index through one of three addressing forms. The first is a full 5-bit direct selector. The second is a short 4-bit selector that reaches only the upper sixteen registers, which immediate-operand instructions use. The third is an indirect form in which register 30 acts as a pointer into the file itself. Both operands can be read and a result written within a single clock cycle.

The read ports are combinational. When a read and the write resolve to the same register in the same cycle, the read returns the value being written. The write is synchronous. Instruction decode, the ALU and the status flags live outside this block. The core drives a 2-bit mode and a 5-bit selector per port, and the block does the index resolution.

Top module: `regfile_ptr`

## Requirements
- R1: A synchronous, active-high `rst` clears all 32 registers to 0x00 on the rising edge. Reset takes priority over a write in the same cycle.
- R2: A register changes only on a rising edge with `wr_en` high. With `wr_en` low, every register keeps its value.
- R3: Mode 2'b00 (direct) selects register `sel[4:0]`, so any of registers 0 to 31 can be chosen. This applies to both read ports and to the write port.
- R4: Mode 2'b01 (upper half) selects register 16 + `sel[3:0]`. `sel[4]` is ignored.
- R5: Mode 2'b10 (indirect) selects the register whose index is the low 5 bits of register 30. Bits 7 to 5 of register 30 and the port's `sel` are ignored.
- R6: An indirect access resolves its index from register 30 as stored before the edge. This holds even when register 30 is written in the same cycle.
- R7: Mode 2'b11 behaves exactly like direct mode.
- R8: The two read ports resolve and return data independently and combinationally. Each returns its register's contents in the same cycle, with no clock edge in between.
- R9: When `wr_en` is high and a read port resolves to the same register as the write port, that read port returns `wr_data`.
- R10: After register 30 is written, later indirect accesses use the new pointer value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 2 | Addressing mode of the write port |
| wr_sel | input | 5 | Selector of the write port |
| wr_data | input | 8 | Data to write |
| rda_mode | input | 2 | Addressing mode of read port A |
| rda_sel | input | 5 | Selector of read port A |
| rda_data | output | 8 | Read port A data |
| rdb_mode | input | 2 | Addressing mode of read port B |
| rdb_sel | input | 5 | Selector of read port B |
| rdb_data | output | 8 | Read port B data |

## Verification
Two directed sweeps follow reset, one before the file is filled and one after, and they show that every register reads zero. A full fill with distinct values then tells apart all 32 direct indices. Paired upper-half selectors that differ only in bit 4 show that bit is ignored. A pointer value with its top bits set shows that only five bits steer indirect access, and writing register 30 while reading indirectly in the same cycle separates the old pointer from the new one. A long seeded random run mixes all four modes, enables and frequent writes to register 30 and to the read targets, which exercises forwarding on both ports against a bench model.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    SEL_DIRECT   = 2'b00,
    SEL_UPPER    = 2'b01,
    SEL_INDIRECT = 2'b10,
    SEL_ALT      = 2'b11
  } sel_mode_e;
endpackage

// File: rtl/rf_sel_decode.sv
module rf_sel_decode #(
  parameter int ADDR_W = 5
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] sel,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] idx
);
  import rf_pkg::*;
  localparam int SHORT_W = ADDR_W - 1;

  sel_mode_e m;
  assign m = sel_mode_e'(mode);

  always_comb begin
    unique case (m)
      SEL_UPPER:    idx = {1'b1, sel[SHORT_W-1:0]};
      SEL_INDIRECT: idx = ptr;
      default:      idx = sel;
    endcase
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int PTR_IDX = 30
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [(1<<ADDR_W)*DATA_W-1:0] file_flat,
  output logic [ADDR_W-1:0]             ptr
);
  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= '0;
      else if (we && waddr == ADDR_W'(g))
        regs_q[g] <= wdata;
    end
    assign file_flat[g*DATA_W +: DATA_W] = regs_q[g];
  end

  assign ptr = regs_q[PTR_IDX][ADDR_W-1:0];
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic [(1<<ADDR_W)*DATA_W-1:0] file_flat,
  input  logic [ADDR_W-1:0]             idx,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             data
);
  logic [DATA_W-1:0] stored;
  logic              hit;

  assign stored = file_flat[idx*DATA_W +: DATA_W];
  assign hit    = we && (waddr == idx);
  assign data   = hit ? wdata : stored;
endmodule

// File: rtl/regfile_ptr.sv
module regfile_ptr #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int PTR_IDX = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic [ADDR_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rda_mode,
  input  logic [ADDR_W-1:0] rda_sel,
  output logic [DATA_W-1:0] rda_data,
  input  logic [1:0]        rdb_mode,
  input  logic [ADDR_W-1:0] rdb_sel,
  output logic [DATA_W-1:0] rdb_data
);
  localparam int NREG   = 1 << ADDR_W;
  localparam int NRD    = 2;
  localparam int FLAT_W = NREG * DATA_W;

  logic [FLAT_W-1:0] file_flat;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] wr_idx;
  logic [ADDR_W-1:0] rd_idx  [NRD];
  logic [1:0]        rd_mode [NRD];
  logic [ADDR_W-1:0] rd_sel  [NRD];
  logic [DATA_W-1:0] rd_data [NRD];

  assign rd_mode[0] = rda_mode;
  assign rd_mode[1] = rdb_mode;
  assign rd_sel[0]  = rda_sel;
  assign rd_sel[1]  = rdb_sel;
  assign rda_data   = rd_data[0];
  assign rdb_data   = rd_data[1];

  rf_sel_decode #(.ADDR_W(ADDR_W)) u_wdec (
    .mode(wr_mode), .sel(wr_sel), .ptr(ptr), .idx(wr_idx)
  );

  rf_storage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_IDX(PTR_IDX)) u_store (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_idx), .wdata(wr_data),
    .file_flat(file_flat), .ptr(ptr)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_sel_decode #(.ADDR_W(ADDR_W)) u_rdec (
      .mode(rd_mode[p]), .sel(rd_sel[p]), .ptr(ptr), .idx(rd_idx[p])
    );
    rf_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
      .file_flat(file_flat), .idx(rd_idx[p]), .we(wr_en),
      .waddr(wr_idx), .wdata(wr_data), .data(rd_data[p])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 5,
  parameter int PTR_IDX = 30
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_idx,
  input logic [DATA_W-1:0]             wr_data,
  input logic [1:0]                    rda_mode,
  input logic [ADDR_W-1:0]             a_idx,
  input logic [DATA_W-1:0]             rda_data,
  input logic [ADDR_W-1:0]             b_idx,
  input logic [DATA_W-1:0]             rdb_data,
  input logic [(1<<ADDR_W)*DATA_W-1:0] file_flat
);
  localparam int FLAT_W = (1 << ADDR_W) * DATA_W;

  function automatic logic [DATA_W-1:0] word_at(input logic [FLAT_W-1:0] f,
                                                input logic [ADDR_W-1:0] i);
    return f[i*DATA_W +: DATA_W];
  endfunction

  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> word_at(file_flat, $past(wr_idx)) == $past(wr_data));

  a_r2_no_write_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(file_flat));

  a_r4_upper_half: assert property (@(posedge clk) disable iff (rst)
    rda_mode == 2'b01 |-> a_idx[ADDR_W-1]);

  a_r5_indirect_ptr: assert property (@(posedge clk) disable iff (rst)
    rda_mode == 2'b10 |-> a_idx == word_at(file_flat, ADDR_W'(PTR_IDX))[ADDR_W-1:0]);

  a_r9_forward_a: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a_idx == wr_idx) |-> rda_data == wr_data);

  a_r9_forward_b: assert property (@(posedge clk) disable iff (rst)
    (wr_en && b_idx == wr_idx) |-> rdb_data == wr_data);

  a_r8_read_a: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && a_idx == wr_idx) |-> rda_data == word_at(file_flat, a_idx));

  a_r8_read_b: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && b_idx == wr_idx) |-> rdb_data == word_at(file_flat, b_idx));
endmodule

bind regfile_ptr rf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_IDX(PTR_IDX)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rda_mode(rda_mode), .a_idx(rd_idx[0]), .rda_data(rda_data),
  .b_idx(rd_idx[1]), .rdb_data(rdb_data), .file_flat(file_flat)
);

// File: tb/regfile_ptr_bench.sv
module regfile_ptr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst, wr_en;
  logic [1:0] wr_mode, rda_mode, rdb_mode;
  logic [4:0] wr_sel, rda_sel, rdb_sel;
  logic [7:0] wr_data, rda_data, rdb_data;

  regfile_ptr u_regfile_ptr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .wr_sel(wr_sel),
    .wr_data(wr_data), .rda_mode(rda_mode), .rda_sel(rda_sel), .rda_data(rda_data),
    .rdb_mode(rdb_mode), .rdb_sel(rdb_sel), .rdb_data(rdb_data)
  );

  logic [7:0] model [NREG];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string phase  = "";

  function automatic logic [4:0] resolve(input logic [1:0] m, input logic [4:0] s);
    case (m)
      2'b01:   return {1'b1, s[3:0]};
      2'b10:   return model[30][4:0];
      default: return s;
    endcase
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle: check both reads before the edge, then update the model.
  task automatic cycle(input logic we, input logic [1:0] wm, input logic [4:0] ws,
                       input logic [7:0] wd, input logic [1:0] am, input logic [4:0] as_,
                       input logic [1:0] bm, input logic [4:0] bs);
    logic [4:0] ia, ib, iw;
    logic [7:0] ea, eb;
    string ta, tb;
    wr_en = we; wr_mode = wm; wr_sel = ws; wr_data = wd;
    rda_mode = am; rda_sel = as_; rdb_mode = bm; rdb_sel = bs;
    #1;
    ia = resolve(am, as_); ib = resolve(bm, bs); iw = resolve(wm, ws);
    ea = (we && iw == ia) ? wd : model[ia];
    eb = (we && iw == ib) ? wd : model[ib];
    ta = (we && iw == ia) ? "R9" : mode_tag(am);
    tb = (we && iw == ib) ? "R9" : mode_tag(bm);
    if (phase != "") begin ta = phase; tb = phase; end
    chk({ta, " portA R8"}, rda_data, ea);
    chk({tb, " portB R8"}, rdb_data, eb);
    @(posedge clk);
    if (we) model[iw] = wd;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic hold_write);
    rst = 1'b1; wr_en = hold_write; wr_mode = 2'b00; wr_sel = 5'd7; wr_data = 8'hFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
  endtask

  task automatic sweep_zero();
    phase = "R1";
    for (int i = 0; i < NREG/2; i++)
      cycle(1'b0, 2'b00, 5'd0, 8'h00, 2'b00, 5'(i), 2'b00, 5'(i + NREG/2));
    phase = "";
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rda_mode = 0; rda_sel = 0; rdb_mode = 0; rdb_sel = 0;
    @(negedge clk);
    do_reset(1'b0);
    sweep_zero();

    // R3: fill every register with a distinct value through direct writes
    for (int i = 0; i < NREG; i++)
      cycle(1'b1, 2'b00, 5'(i), 8'(i * 7 + 1), 2'b00, 5'(i), 2'b00, 5'((i + 1) % NREG));
    for (int i = 0; i < NREG/2; i++)
      cycle(1'b0, 2'b00, 5'd0, 8'h00, 2'b00, 5'(i), 2'b00, 5'(i + 16));

    // R4: sel[4] ignored in upper-half mode, both reach r18
    cycle(1'b0, 2'b00, 5'd0, 8'h00, 2'b01, 5'b00010, 2'b01, 5'b10010);
    cycle(1'b1, 2'b01, 5'b00101, 8'hA5, 2'b00, 5'd21, 2'b00, 5'd5);
    cycle(1'b0, 2'b00, 5'd0, 8'h00, 2'b00, 5'd21, 2'b01, 5'b10101);

    // R5: pointer with top bits set, low five bits = 5
    cycle(1'b1, 2'b00, 5'd30, 8'hE5, 2'b00, 5'd30, 2'b00, 5'd5);
    cycle(1'b0, 2'b00, 5'd0, 8'h00, 2'b10, 5'd17, 2'b10, 5'd0);

    // R6: r30 written this cycle, indirect read still uses old pointer (r5)
    phase = "R6";
    cycle(1'b1, 2'b00, 5'd30, 8'h09, 2'b10, 5'd0, 2'b00, 5'd5);
    // R10: new pointer now selects r9
    phase = "R10";
    cycle(1'b0, 2'b00, 5'd0, 8'h00, 2'b10, 5'd0, 2'b00, 5'd9);
    phase = "";

    // R5 indirect write goes to r9, forwarded on port A
    cycle(1'b1, 2'b10, 5'd3, 8'h5A, 2'b00, 5'd9, 2'b10, 5'd0);
    cycle(1'b0, 2'b00, 5'd0, 8'h00, 2'b00, 5'd9, 2'b00, 5'd3);

    // R7: mode 11 acts as direct
    cycle(1'b1, 2'b11, 5'd2, 8'hC3, 2'b11, 5'd2, 2'b11, 5'd12);
    cycle(1'b0, 2'b00, 5'd0, 8'h00, 2'b00, 5'd2, 2'b11, 5'd2);

    // R2: write enable low with data on the bus has no effect
    cycle(1'b0, 2'b00, 5'd4, 8'h77, 2'b00, 5'd4, 2'b00, 5'd4);
    cycle(1'b0, 2'b00, 5'd0, 8'h00, 2'b00, 5'd4, 2'b11, 5'd4);

    // Random mix of all modes, with frequent pointer writes and collisions
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] ws, as_, bs;
      ws  = ($urandom % 6 == 0) ? 5'd30 : 5'($urandom);
      as_ = ($urandom % 4 == 0) ? ws : 5'($urandom);
      bs  = 5'($urandom);
      cycle(1'($urandom), 2'($urandom), ws, 8'($urandom),
            2'($urandom), as_, 2'($urandom), bs);
    end

    // R1: reset with a write held active, reset wins
    do_reset(1'b1);
    sweep_zero();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule